// File: doc/BRIEF.md
# Mailbox Receive Queue

This block is the receiving end of an inter-processor mailbox. A producer delivers 64-bit messages, each tagged with the channel that sent it, into a circular queue of parameterised depth. A local host then works through a small register window. It reads the oldest message (low word, high word and channel) without removing it, and writes a pop command when it has finished with that message.

Occupancy is not reported as a count. The host sees the raw circular write and read pointers and a full bit, and uses the full bit to tell a full queue from an empty one when the pointers are equal. A not-empty condition stays pending for as long as any message is stored. It drives an interrupt line through a mask bit that resets to masked.

The push side is a valid/ready stream. `in_ready` is high whenever the queue has room. A beat is accepted on a clock edge where both `in_valid` and `in_ready` are high. A beat offered while `in_ready` is low is not stored and has no other effect, so the producer must hold it or drop it. The register side is a plain single-cycle write strobe with a combinational read.

Top module: `ipc_rx_queue`

## Requirements
- R1: A beat accepted while `in_ready` is high is stored at the write pointer. The write pointer then advances by one and wraps from DEPTH-1 to 0. `in_ready` is high exactly when the queue is not full.
- R2: Reads have no side effects. A read at offset 0x00 returns the oldest entry's channel, zero-extended. Offset 0x04 returns the low data word and offset 0x08 the high data word.
- R3: A beat offered while the queue is full is discarded. The write pointer and the stored contents stay unchanged.
- R4: A write to offset 0x0C with bit 0 set removes the oldest entry when the queue holds at least one entry. The read pointer then advances and wraps from DEPTH-1 to 0, and the full bit clears. The same write on an empty queue changes nothing.
- R5: Reading offset 0x14 returns the read pointer in bits 31:24, the write pointer in bits 23:16 and the full bit in bit 2. All other bits read as 0. The full bit sets when an accepted beat makes the pointers equal. Equal pointers with the full bit clear mean the queue is empty.
- R6: Offset 0x24 is read-only and returns DEPTH-1.
- R7: Writing the value 0 to offset 0x10 clears both pointers and the full bit, which empties the queue. Writing any nonzero value there has no effect.
- R8: Offset 0x1C holds a 5-bit mask that is writable and reads back. It resets to 0x1F. While bit 0 of the mask is 1, `irq` stays low.
- R9: Bit 0 at offset 0x18 is the pending flag, and it is set on each clock edge where the queue is non-empty. Writing 1 to that bit clears it for one cycle. If entries remain, the flag sets again on the following edge. `irq` equals the pending flag AND NOT mask bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers a message |
| in_ready | output | 1 | Queue has room; a beat is taken when high together with in_valid |
| in_lo | input | 32 | Message low word |
| in_hi | input | 32 | Message high word |
| in_chan | input | CHAN_W | Sending channel of the message |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Masked not-empty interrupt |

## Verification
The bench builds the queue with DEPTH = 4 and CHAN_W = 3. With a small depth, a few pushes reach the full state. The bench then checks the discard of extra beats and walks both pointers through their wrap from 3 to 0. This exercises the equal-pointer ambiguity in both its full and empty forms. The three-bit channel lets each message carry a distinct tag, and a scoreboard checks the tags on the way out.

// File: rtl/ipc_rx_pkg.sv
package ipc_rx_pkg;
  localparam int OFS_W = 6;
  localparam logic [OFS_W-1:0] OFS_CHAN  = 6'h00;
  localparam logic [OFS_W-1:0] OFS_LO    = 6'h04;
  localparam logic [OFS_W-1:0] OFS_HI    = 6'h08;
  localparam logic [OFS_W-1:0] OFS_POP   = 6'h0C;
  localparam logic [OFS_W-1:0] OFS_FLUSH = 6'h10;
  localparam logic [OFS_W-1:0] OFS_STAT  = 6'h14;
  localparam logic [OFS_W-1:0] OFS_PEND  = 6'h18;
  localparam logic [OFS_W-1:0] OFS_MASK  = 6'h1C;
  localparam logic [OFS_W-1:0] OFS_DEPTH = 6'h24;

  localparam int STAT_FULL_BIT = 2;
  localparam int STAT_WR_LSB   = 16;
  localparam int STAT_RD_LSB   = 24;
  localparam int PTR_FIELD_W   = 8;
  localparam int MASK_W        = 5;
  localparam logic [MASK_W-1:0] MASK_RESET = 5'h1F;
endpackage

// File: rtl/ipc_rx_ptrs.sv
module ipc_rx_ptrs #(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          flush,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] wr_nx, rd_nx;

  assign wr_nx   = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
  assign rd_nx   = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
  assign empty   = (wr_ptr == rd_ptr) && !full;
  assign push_ok = push_req && !full && !flush;
  assign pop_ok  = pop_req && !empty && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      full   <= 1'b0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      full   <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_nx;
      if (pop_ok)  rd_ptr <= rd_nx;
      if (pop_ok)
        full <= 1'b0;
      else if (push_ok && (wr_nx == rd_ptr))
        full <= 1'b1;
    end
  end
endmodule

// File: rtl/ipc_rx_store.sv
module ipc_rx_store #(
  parameter int DEPTH = 8,
  parameter int W     = 67,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [PW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (waddr == PW'(i))) slot[i] <= wdata;
    end
  end

  assign rdata = slot[raddr];
endmodule

// File: rtl/ipc_rx_regs.sv
module ipc_rx_regs
  import ipc_rx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CHAN_W = 3,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [CHAN_W-1:0] head_chan,
  input  logic [31:0]       head_lo,
  input  logic [31:0]       head_hi,
  input  logic [PW-1:0]     wr_ptr,
  input  logic [PW-1:0]     rd_ptr,
  input  logic              full,
  input  logic              empty,
  output logic              pop_req,
  output logic              flush,
  output logic              pend,
  output logic              pend_clr,
  output logic              mask0,
  output logic              irq
);
  logic [MASK_W-1:0] mask;
  logic [31:0]       stat_word;

  assign pop_req  = reg_we && (reg_addr == OFS_POP) && reg_wdata[0];
  assign flush    = reg_we && (reg_addr == OFS_FLUSH) && (reg_wdata == 32'd0);
  assign pend_clr = reg_we && (reg_addr == OFS_PEND) && reg_wdata[0];
  assign mask0    = mask[0];
  assign irq      = pend && !mask[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= MASK_RESET;
      pend <= 1'b0;
    end else begin
      if (reg_we && (reg_addr == OFS_MASK)) mask <= reg_wdata[MASK_W-1:0];
      if (pend_clr)
        pend <= 1'b0;
      else if (!empty)
        pend <= 1'b1;
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[STAT_RD_LSB +: PTR_FIELD_W] = PTR_FIELD_W'(rd_ptr);
    stat_word[STAT_WR_LSB +: PTR_FIELD_W] = PTR_FIELD_W'(wr_ptr);
    stat_word[STAT_FULL_BIT] = full;
  end

  always_comb begin
    unique case (reg_addr)
      OFS_CHAN:  reg_rdata = 32'(head_chan);
      OFS_LO:    reg_rdata = head_lo;
      OFS_HI:    reg_rdata = head_hi;
      OFS_STAT:  reg_rdata = stat_word;
      OFS_PEND:  reg_rdata = {31'd0, pend};
      OFS_MASK:  reg_rdata = 32'(mask);
      OFS_DEPTH: reg_rdata = 32'(DEPTH - 1);
      default:   reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/ipc_rx_queue.sv
module ipc_rx_queue
  import ipc_rx_pkg::*;
#(
  parameter int DEPTH  = 8,   // at most 256: pointer fields are 8 bits
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_lo,
  input  logic [31:0]       in_hi,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = 64 + CHAN_W;

  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, push_ok, pop_ok, pop_req, flush;
  logic          pend, pend_clr, mask0;
  logic [EW-1:0] head;

  assign in_ready = !full;

  ipc_rx_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push_req(in_valid), .pop_req(pop_req),
    .flush(flush), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full),
    .empty(empty), .push_ok(push_ok), .pop_ok(pop_ok)
  );

  ipc_rx_store #(.DEPTH(DEPTH), .W(EW)) u_store (
    .clk(clk), .we(push_ok), .waddr(wr_ptr),
    .wdata({in_chan, in_hi, in_lo}), .raddr(rd_ptr), .rdata(head)
  );

  ipc_rx_regs #(.DEPTH(DEPTH), .CHAN_W(CHAN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .head_chan(head[EW-1:64]), .head_lo(head[31:0]), .head_hi(head[63:32]),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full), .empty(empty),
    .pop_req(pop_req), .flush(flush), .pend(pend), .pend_clr(pend_clr),
    .mask0(mask0), .irq(irq)
  );
endmodule

// File: rtl/ipc_rx_queue_sva.sv
module ipc_rx_queue_sva #(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic          full,
  input logic          empty,
  input logic          pop_ok,
  input logic          flush,
  input logic          pend,
  input logic          pend_clr,
  input logic          mask0,
  input logic          irq
);
  // R3: a full queue keeps its write pointer unless flushed
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !flush) |=> $stable(wr_ptr));

  // R4: any pop from a full queue clears the full bit
  a_r4_pop_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && full) |=> !full);

  // R5: full only with equal pointers
  a_r5_full_ptrs_equal: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (wr_ptr == rd_ptr));

  // R7: flush empties the queue
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (wr_ptr == '0 && rd_ptr == '0 && !full));

  // R8: masked line stays low
  a_r8_mask_gates_irq: assert property (@(posedge clk) disable iff (!rst_n)
    mask0 |-> !irq);

  // R9: pending re-latches while entries remain
  a_r9_pend_relatch: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pend_clr) |=> pend);

  // R9: a clear write drops the flag for one cycle
  a_r9_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |=> !pend);
endmodule

bind ipc_rx_queue ipc_rx_queue_sva #(.PW(PW)) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full),
  .empty(empty), .pop_ok(pop_ok), .flush(flush), .pend(pend),
  .pend_clr(pend_clr), .mask0(mask0), .irq(irq)
);

// File: tb/ipc_rx_queue_bench.sv
`timescale 1ns/1ps
module ipc_rx_queue_bench;
  localparam int DEPTH  = 4;
  localparam int CHAN_W = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [31:0]       in_lo = '0, in_hi = '0;
  logic [CHAN_W-1:0] in_chan = '0;
  logic              reg_we = 1'b0;
  logic [5:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [66:0] sb[$];

  always #10 clk = ~clk;   // 50 MHz

  ipc_rx_queue #(.DEPTH(DEPTH), .CHAN_W(CHAN_W)) u_ipc_rx_queue (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_lo(in_lo), .in_hi(in_hi), .in_chan(in_chan), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [31:0] stat(input int r, input int w, input bit f);
    return (32'(r) << 24) | (32'(w) << 16) | (32'(f) << 2);
  endfunction

  // driver: offers a beat; records it on the scoreboard when it is accepted
  task automatic push(input logic [31:0] lo, input logic [31:0] hi, input logic [2:0] ch);
    @(negedge clk);
    in_valid = 1'b1; in_lo = lo; in_hi = hi; in_chan = ch;
    if (in_ready) sb.push_back({ch, hi, lo});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: compares the head with the oldest scoreboard item, then pops
  task automatic take();
    logic [31:0] d;
    logic [66:0] e;
    e = sb.pop_front();
    rd(6'h00, d); check("R2 chan", d, 32'(e[66:64]));
    rd(6'h04, d); check("R2 low",  d, e[31:0]);
    rd(6'h08, d); check("R2 high", d, e[63:32]);
    wr(6'h0C, 32'h1);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(6'h14, d); check("R5 reset status", d, stat(0, 0, 0));
    rd(6'h1C, d); check("R8 reset mask", d, 32'h1F);
    rd(6'h18, d); check("R9 reset pend", d, 32'h0);
    rd(6'h24, d); check("R6 depth", d, 32'(DEPTH - 1));
    check("R1 ready at reset", 32'(in_ready), 32'h1);

    push(32'h1111_0001, 32'hAAAA_0001, 3'd1);
    push(32'h1111_0002, 32'hAAAA_0002, 3'd2);
    push(32'h1111_0003, 32'hAAAA_0003, 3'd3);
    rd(6'h14, d); check("R1 wr after 3", d, stat(0, 3, 0));
    rd(6'h18, d); check("R9 pend set", d, 32'h1);
    check("R8 irq masked", 32'(irq), 32'h0);
    wr(6'h1C, 32'h1E);
    rd(6'h1C, d); check("R8 mask readback", d, 32'h1E);
    check("R9 irq unmasked", 32'(irq), 32'h1);

    wr(6'h18, 32'h1);
    rd(6'h18, d); check("R9 pend cleared", d, 32'h0);
    check("R9 irq low after clear", 32'(irq), 32'h0);
    @(negedge clk);
    rd(6'h18, d); check("R9 pend relatch", d, 32'h1);

    push(32'h1111_0004, 32'hAAAA_0004, 3'd4);
    rd(6'h14, d); check("R5 full wrap", d, stat(0, 0, 1));
    check("R1 ready low when full", 32'(in_ready), 32'h0);
    push(32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'd7);
    rd(6'h14, d); check("R3 discard keeps ptrs", d, stat(0, 0, 1));

    take();
    rd(6'h14, d); check("R4 pop clears full", d, stat(1, 0, 0));
    take(); take(); take();
    rd(6'h14, d); check("R4 empty after wrap", d, stat(0, 0, 0));
    wr(6'h0C, 32'h1);
    rd(6'h14, d); check("R4 pop on empty ignored", d, stat(0, 0, 0));

    wr(6'h18, 32'h1);
    @(negedge clk);
    rd(6'h18, d); check("R9 pend stays clear when empty", d, 32'h0);

    push(32'h2222_0005, 32'hBBBB_0005, 3'd5);
    push(32'h2222_0006, 32'hBBBB_0006, 3'd6);
    take();
    push(32'h2222_0007, 32'hBBBB_0007, 3'd0);
    rd(6'h14, d); check("R1 R4 interleave", d, stat(1, 3, 0));

    wr(6'h10, 32'h5);
    rd(6'h14, d); check("R7 nonzero flush ignored", d, stat(1, 3, 0));
    take();
    wr(6'h10, 32'h0);
    sb.delete();
    rd(6'h14, d); check("R7 flush clears", d, stat(0, 0, 0));
    wr(6'h18, 32'h1);
    @(negedge clk);
    check("R9 irq idle after flush", 32'(irq), 32'h0);

    push(32'h3333_0008, 32'hCCCC_0008, 3'd2);
    take();
    rd(6'h14, d); check("R1 after flush reuse", d, stat(1, 1, 0));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule